// File: doc/BRIEF.md
# Receive idle time-out counter

This block watches the character traffic of two serial receivers and reports when the line has gone quiet. It is a down-counter that is advanced by an external counter clock enable (`tick`). It is loaded from a 16-bit reload value, which arrives as a high byte and a low byte. While time-out mode is active, every character that a receiver hands over to its FIFO restarts the count. If the count reaches zero before the next character arrives, a counter-ready flag is raised. When the mask input allows it, an interrupt follows.

Each receiver turns time-out mode on and off through its own command write port. Both write ports share one command byte. The mode is active while at least one receiver has it on. While the mode is active, a character from any receiver that has the mode on restarts the shared counter. A character from a receiver that does not have the mode on is ignored. Time-out mode takes over the counter: the ordinary start and stop counter commands have no effect until every receiver has turned the mode off. With the mode off, those two commands run the counter as a one-shot.

The controller has four states:
- **IDLE**: stopped, mode inactive.
- **ARMED**: stopped, waiting for a character, or stopped after an expiry.
- **PEND**: halted; the reload happens on the next tick.
- **COUNT**: decrementing.

The transitions between them are:
- **on-command**: any state to ARMED.
- **mode-exit**: any state to IDLE, when the last enable is removed.
- **restart**: a character in mode, or a start command in normal operation, takes any state to PEND.
- **stop**: any state to IDLE, in normal operation.
- **load**: PEND to COUNT on a tick.
- **expire**: COUNT to ARMED in mode, or COUNT to IDLE in normal operation, on the tick that reaches zero.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `cnt_ready`, `irq`, `mode_act` and `count` are all 0.
- R2: While the mode is active, a character strobe stops the counter, so the count does not change in that cycle. The first `tick` after the strobe loads the reload value `{reload_hi, reload_lo}` without decrementing. Each later `tick` decrements the count by one.
- R3: Once the count has been loaded with value N, `cnt_ready` becomes 1 on the N-th following `tick`, when the count reaches 0. In time-out mode the counter then stays stopped at 0.
- R4: `irq` is 1 exactly when `cnt_ready` is 1 and `irq_mask` is 1.
- R5: While the mode is active, a character strobe from an enabled receiver clears `cnt_ready`, and so withdraws `irq`.
- R6: A command write whose upper nibble is 0xA (`cmd_data[7:4]`) turns the mode on for the receivers whose `cmd_wr` bit is set. It also clears `cnt_ready` and holds the counter stopped, so that neither `count` nor `cnt_ready` changes on ticks until a character arrives.
- R7: A command write whose upper nibble is 0xC turns the mode off for the receivers whose `cmd_wr` bit is set. When no receiver has the mode on any longer, `mode_act` falls and the counter stops. `count` and `cnt_ready` keep their values.
- R8: Upper nibble 0x8 is the start command and 0x9 is the stop command. While the mode is active, both are ignored. With the mode inactive, start behaves like a restart: the reload happens on the next tick, the counter then counts down, and it stops at 0 with `cnt_ready` set. Stop halts the counter and clears `cnt_ready`. Any other upper nibble has no effect.
- R9: A character restarts the counter only if it comes from a receiver that has the mode on. Either receiver alone can restart it, so an expiry needs both enabled receivers to be idle for the whole period.
- R10: A reload value of 0 loads a count of 65536.
- R11: A mode-on command in the same cycle as a character takes priority over the character. A character in the same cycle as the expiring tick takes priority over the expiry, so `cnt_ready` stays 0 and a restart begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| char_stb | input | 2 | Per-receiver pulse: a character has been moved into the receive FIFO |
| cmd_wr | input | 2 | Per-receiver command write strobe |
| cmd_data | input | 8 | Command byte; the upper nibble selects the operation |
| reload_hi | input | 8 | Upper byte of the reload value |
| reload_lo | input | 8 | Lower byte of the reload value |
| irq_mask | input | 1 | Interrupt mask bit for counter-ready |
| cnt_ready | output | 1 | Counter-ready status |
| irq | output | 1 | Interrupt request, active high |
| mode_act | output | 1 | Time-out mode is active for at least one receiver |
| count | output | 17 | Present counter value |

## Verification
Two pairs of actions can fall in the same cycle:
- A character strobe can arrive on the very tick that would take the count from 1 to 0.
- A mode-on command can arrive together with a character.

The bench provokes the first pair deliberately, by pacing ticks after a load and placing a strobe on the final tick. It then judges that `cnt_ready` stays 0 and that the next tick reloads the count. It forces the second pair with a combined write and strobe, and expects the counter to sit in the held state. Random traffic with short reload values also produces both pairs by chance. Every cycle is compared with a reference model in the bench that applies the stated priorities.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PEND  = 2'd2,
        ST_COUNT = 2'd3
    } tmo_state_e;

    localparam logic [3:0] OP_TMO_ON   = 4'hA;
    localparam logic [3:0] OP_TMO_OFF  = 4'hC;
    localparam logic [3:0] OP_CT_START = 4'h8;
    localparam logic [3:0] OP_CT_STOP  = 4'h9;

endpackage

// File: rtl/rxto_cmd_regs.sv
module rxto_cmd_regs
    import rxto_pkg::*;
#(
    parameter int NRX = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NRX-1:0] cmd_wr,
    input  logic [3:0]     cmd_op,
    input  logic [NRX-1:0] char_stb,
    output logic [NRX-1:0] mode_en_q,
    output logic [NRX-1:0] mode_en_d,
    output logic           on_any,
    output logic           start_any,
    output logic           stop_any,
    output logic           hit
);

    logic [NRX-1:0] on_vec;
    logic [NRX-1:0] off_vec;

    for (genvar g = 0; g < NRX; g++) begin : g_rx
        assign on_vec[g]    = cmd_wr[g] && (cmd_op == OP_TMO_ON);
        assign off_vec[g]   = cmd_wr[g] && (cmd_op == OP_TMO_OFF);
        assign mode_en_d[g] = on_vec[g] | (mode_en_q[g] & ~off_vec[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_en_q[g] <= 1'b0;
            end else begin
                mode_en_q[g] <= mode_en_d[g];
            end
        end
    end

    assign on_any    = |on_vec;
    assign start_any = (|cmd_wr) && (cmd_op == OP_CT_START);
    assign stop_any  = (|cmd_wr) && (cmd_op == OP_CT_STOP);
    assign hit       = |(char_stb & mode_en_q);

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] reload_val,
    output logic [CW:0]   count,
    output logic          at_one
);

    localparam logic [CW:0] FULL_SPAN = {1'b1, {CW{1'b0}}};

    logic [CW:0] load_val;

    assign load_val = (reload_val == '0) ? FULL_SPAN : {1'b0, reload_val};
    assign at_one   = (count == {{CW{1'b0}}, 1'b1});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rxto_fsm.sv
module rxto_fsm
    import rxto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mode_act,
    input  logic       mode_next,
    input  logic       on_any,
    input  logic       start_any,
    input  logic       stop_any,
    input  logic       hit,
    input  logic       at_one,
    output tmo_state_e st_q,
    output logic       load,
    output logic       dec,
    output logic       rdy_q
);

    tmo_state_e st_d;
    logic       set_rdy;
    logic       clr_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        load    = 1'b0;
        dec     = 1'b0;
        set_rdy = 1'b0;
        clr_rdy = 1'b0;
        if (on_any) begin
            st_d    = ST_ARMED;
            clr_rdy = 1'b1;
        end else if (mode_act && !mode_next) begin
            st_d = ST_IDLE;
        end else if (mode_act && hit) begin
            st_d    = ST_PEND;
            clr_rdy = 1'b1;
        end else if (!mode_act && stop_any) begin
            st_d    = ST_IDLE;
            clr_rdy = 1'b1;
        end else if (!mode_act && start_any) begin
            st_d = ST_PEND;
        end else if (tick) begin
            unique case (st_q)
                ST_PEND: begin
                    load = 1'b1;
                    st_d = ST_COUNT;
                end
                ST_COUNT: begin
                    dec = 1'b1;
                    if (at_one) begin
                        set_rdy = 1'b1;
                        st_d    = mode_act ? ST_ARMED : ST_IDLE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else if (clr_rdy) begin
            rdy_q <= 1'b0;
        end else if (set_rdy) begin
            rdy_q <= 1'b1;
        end
    end

    AST_RDY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(tick)); // R3
    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act && mode_next && hit && !on_any) |=> !rdy_q); // R5
    AST_ON_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        on_any |=> (st_q == ST_ARMED && !rdy_q)); // R6
    AST_MODE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_act |-> (st_q != ST_IDLE)); // R8

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int NRX    = 2,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NRX-1:0]      char_stb,
    input  logic [NRX-1:0]      cmd_wr,
    input  logic [7:0]          cmd_data,
    input  logic [BYTE_W-1:0]   reload_hi,
    input  logic [BYTE_W-1:0]   reload_lo,
    input  logic                irq_mask,
    output logic                cnt_ready,
    output logic                irq,
    output logic                mode_act,
    output logic [2*BYTE_W:0]   count
);

    localparam int CW = 2 * BYTE_W;

    logic [NRX-1:0] mode_en_q;
    logic [NRX-1:0] mode_en_d;
    logic           on_any;
    logic           start_any;
    logic           stop_any;
    logic           hit;
    logic           load;
    logic           dec;
    logic           at_one;
    logic           rdy_q;
    tmo_state_e     st_q;
    logic           unused_cmd_low;

    assign unused_cmd_low = ^cmd_data[3:0];

    rxto_cmd_regs #(.NRX(NRX)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_op    (cmd_data[7:4]),
        .char_stb  (char_stb),
        .mode_en_q (mode_en_q),
        .mode_en_d (mode_en_d),
        .on_any    (on_any),
        .start_any (start_any),
        .stop_any  (stop_any),
        .hit       (hit)
    );

    rxto_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode_act  (|mode_en_q),
        .mode_next (|mode_en_d),
        .on_any    (on_any),
        .start_any (start_any),
        .stop_any  (stop_any),
        .hit       (hit),
        .at_one    (at_one),
        .st_q      (st_q),
        .load      (load),
        .dec       (dec),
        .rdy_q     (rdy_q)
    );

    rxto_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .dec        (dec),
        .reload_val ({reload_hi, reload_lo}),
        .count      (count),
        .at_one     (at_one)
    );

    assign cnt_ready = rdy_q;
    assign irq       = rdy_q & irq_mask;
    assign mode_act  = |mode_en_q;

    AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED) |=> $stable(count)); // R6
    AST_RDY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_ready) |-> (count == '0)); // R3
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (irq_mask && cnt_ready)); // R4

endmodule

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  char_stb = '0;
    logic [1:0]  cmd_wr = '0;
    logic [7:0]  cmd_data = '0;
    logic [7:0]  reload_hi = '0;
    logic [7:0]  reload_lo = '0;
    logic        irq_mask = 1'b0;
    logic        cnt_ready;
    logic        irq;
    logic        mode_act;
    logic [16:0] count;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model: 0 idle, 1 armed, 2 pend, 3 count
    logic [1:0] m_mode = '0;
    int         m_st = 0;
    int         m_cnt = 0;
    bit         m_rdy = 0;

    always #10 clk = ~clk;

    rx_idle_timeout dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .char_stb  (char_stb),
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .reload_hi (reload_hi),
        .reload_lo (reload_lo),
        .irq_mask  (irq_mask),
        .cnt_ready (cnt_ready),
        .irq       (irq),
        .mode_act  (mode_act),
        .count     (count)
    );

    function automatic int load_value(input logic [7:0] hi, input logic [7:0] lo);
        return ({hi, lo} == 16'd0) ? 65536 : int'({hi, lo});
    endfunction

    task automatic model_step();
        logic [1:0] mode_n;
        bit act, act_n, hit, on_any, start, stop;
        mode_n = m_mode;
        on_any = 0;
        for (int i = 0; i < 2; i++) begin
            if (cmd_wr[i] && cmd_data[7:4] == 4'hA) begin mode_n[i] = 1'b1; on_any = 1; end
            if (cmd_wr[i] && cmd_data[7:4] == 4'hC) mode_n[i] = 1'b0;
        end
        start = (|cmd_wr) && cmd_data[7:4] == 4'h8;
        stop  = (|cmd_wr) && cmd_data[7:4] == 4'h9;
        act   = |m_mode;
        act_n = |mode_n;
        hit   = |(char_stb & m_mode);
        if (on_any) begin m_st = 1; m_rdy = 0; end
        else if (act && !act_n) m_st = 0;
        else if (act && hit) begin m_st = 2; m_rdy = 0; end
        else if (!act && stop) begin m_st = 0; m_rdy = 0; end
        else if (!act && start) m_st = 2;
        else if (tick) begin
            if (m_st == 2) begin m_cnt = load_value(reload_hi, reload_lo); m_st = 3; end
            else if (m_st == 3) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_rdy = 1; m_st = act ? 1 : 0; end
            end
        end
        m_mode = mode_n;
    endtask

    task automatic check(input string tag, input string what, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "cnt_ready", int'(cnt_ready), int'(m_rdy));
        check(tag, "irq", int'(irq), int'(m_rdy & irq_mask));
        check(tag, "mode_act", int'(mode_act), int'(|m_mode));
        check(tag, "count", int'(count), m_cnt);
    endtask

    task automatic cyc(input string tag, input bit tk, input logic [1:0] ch,
                       input logic [1:0] cw, input logic [7:0] cd);
        tick = tk; char_stb = ch; cmd_wr = cw; cmd_data = cd;
        model_step();
        @(negedge clk);
        compare(tag);
        tick = 0; char_stb = '0; cmd_wr = '0; cmd_data = '0;
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1, 2'b00, 2'b00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        check("R1", "count at reset", int'(count), 0);

        reload_hi = 8'h00; reload_lo = 8'd5; irq_mask = 1'b1;
        // R6: mode on for receiver 0, counter held
        cyc("R6", 1, 2'b00, 2'b01, 8'hA0);
        ticks("R6", 4);
        // R9: receiver 1 not enabled, its character is ignored
        cyc("R9", 1, 2'b10, 2'b00, 8'h00);
        ticks("R9", 3);
        // R2: restart, load tick, then countdown
        cyc("R2", 1, 2'b01, 2'b00, 8'h00);
        ticks("R2", 1);
        check("R2", "count after load", int'(count), 5);
        ticks("R3", 4);
        check("R3", "not yet ready", int'(cnt_ready), 0);
        ticks("R3", 1);
        check("R3", "ready on fifth tick", int'(cnt_ready), 1);
        ticks("R3", 3);
        // R4: mask gating
        irq_mask = 1'b0;
        cyc("R4", 0, 2'b00, 2'b00, 8'h00);
        check("R4", "irq masked", int'(irq), 0);
        irq_mask = 1'b1;
        cyc("R4", 0, 2'b00, 2'b00, 8'h00);
        check("R4", "irq unmasked", int'(irq), 1);
        // R5: character after timeout clears ready
        cyc("R5", 0, 2'b01, 2'b00, 8'h00);
        check("R5", "ready cleared", int'(cnt_ready), 0);
        ticks("R2", 5);
        // R11: character on the expiring tick wins
        cyc("R11", 1, 2'b01, 2'b00, 8'h00);
        check("R11", "no expiry", int'(cnt_ready), 0);
        ticks("R11", 1);
        check("R11", "reloaded", int'(count), 5);
        ticks("R3", 5);
        // R8: start and stop ignored in mode
        cyc("R8", 1, 2'b00, 2'b01, 8'h90);
        check("R8", "stop ignored", int'(cnt_ready), 1);
        cyc("R8", 1, 2'b00, 2'b10, 8'h80);
        ticks("R8", 2);
        // R9: both receivers enabled, either restarts
        cyc("R9", 0, 2'b00, 2'b10, 8'hA0);
        cyc("R9", 1, 2'b10, 2'b00, 8'h00);
        ticks("R9", 4);
        cyc("R9", 1, 2'b01, 2'b00, 8'h00);
        ticks("R9", 6);
        check("R9", "expired after both idle", int'(cnt_ready), 1);
        // R7: leaving the mode
        cyc("R7", 1, 2'b00, 2'b01, 8'hC0);
        cyc("R7", 1, 2'b00, 2'b10, 8'hC0);
        check("R7", "mode inactive", int'(mode_act), 0);
        ticks("R7", 3);
        // R8: normal start one-shot, stop
        reload_lo = 8'd3;
        cyc("R8", 0, 2'b00, 2'b01, 8'h80);
        ticks("R8", 6);
        check("R8", "one-shot expired", int'(cnt_ready), 1);
        cyc("R8", 0, 2'b01, 2'b00, 8'h3F);
        cyc("R8", 0, 2'b00, 2'b10, 8'h90);
        check("R8", "stop clears ready", int'(cnt_ready), 0);
        // R11: mode-on beats character
        cyc("R11", 0, 2'b00, 2'b01, 8'hA0);
        cyc("R11", 1, 2'b01, 2'b01, 8'hA0);
        ticks("R11", 3);
        // R10: zero reload is full span
        reload_lo = 8'd0;
        cyc("R10", 0, 2'b01, 2'b00, 8'h00);
        ticks("R10", 1);
        check("R10", "count after zero reload", int'(count), 65536);
        ticks("R10", 65535);
        check("R10", "not yet ready", int'(cnt_ready), 0);
        ticks("R10", 1);
        check("R10", "ready after 65536", int'(cnt_ready), 1);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] ch, cw;
            logic [7:0] cd;
            bit tk;
            int pick;
            if ($urandom_range(0, 99) < 3) begin
                reload_hi = 8'h00;
                reload_lo = 8'($urandom_range(2, 12));
            end
            if ($urandom_range(0, 99) < 5) irq_mask = 1'($urandom_range(0, 1));
            tk = ($urandom_range(0, 1) == 1);
            ch[0] = ($urandom_range(0, 11) == 0);
            ch[1] = ($urandom_range(0, 11) == 0);
            cw = '0; cd = '0;
            if ($urandom_range(0, 39) == 0) begin
                cw = 2'($urandom_range(1, 3));
                pick = $urandom_range(0, 4);
                case (pick)
                    0: cd = 8'hA0;
                    1: cd = 8'hC0;
                    2: cd = 8'h80;
                    3: cd = 8'h90;
                    default: cd = 8'h30;
                endcase
            end
            cyc("R3", tk, ch, cw, cd);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule